// File: doc/BRIEF.md
# PLD Output Macrocell Array

This block is the output stage of a small programmable logic device. It has eight output cells, and one global mode decides how every cell behaves. Each cell takes a sum-of-products result and a product-term enable from the logic array. It applies a per-cell polarity bit and produces a pad value and a pad enable. Each pad can drive as push-pull or as open-drain. The block also returns one feedback signal per cell to the logic array.

A two-bit mode word `{sync, acc}` selects the mode:

| Mode word | Mode |
|---|---|
| 2'b10 | simple |
| 2'b11 | complex |
| 2'b01 | registered |
| 2'b00 | reserved, every pad inactive |

Two dedicated device pins play a part:

- **Registered mode.** The two pins act as the register clock and the active-low global output enable.
- **Simple and complex modes.** The two pins are plain inputs. They reach the array through the feedback slots of the two end cells.

Cells are indexed 0 to 7, going from one end of the pad row to the other. Cells 3 and 4 are the innermost pair. The block works in the `clk` domain and samples the device clock pin for rising edges. Reset is synchronous and active high.

Top module: `pld_olmc_array`

## Requirements
- R1: With mode word 2'b00 every `pad_oe`, `pad_out` and `fb_out` bit is 0, whatever the other inputs are.
- R2: A cell's logic value is `sop_in[i] ^ cfg_pol[i]`. A polarity bit of 1 inverts the sum, and 0 passes it through.
- R3: With `cfg_od[i]`=1 the cell drives `pad_out[i]`=0. It asserts `pad_oe[i]` only when the logic value is 0 and the cell would otherwise be enabled. With `cfg_od[i]`=0, `pad_out[i]` carries the logic value.
- R4: In simple mode (2'b10) a cell with `cfg_in_sel[i]`=0 is always enabled, and a cell with `cfg_in_sel[i]`=1 is tri-stated. Cells 3 and 4 are always enabled whatever their `cfg_in_sel` bit is.
- R5: In simple mode, feedback comes from neighbouring pads:
  - `fb_out[1..3]` carry the pad levels of cells 0..2.
  - `fb_out[4..6]` carry the pad levels of cells 5..7.
  - `fb_out[0]` carries `ded_oe_n`, and `fb_out[7]` carries `ded_clk`.
- R6: In complex mode (2'b11) each cell's enable equals its `pt_oe_in` bit.
- R7: In complex mode, `fb_out[0]` is `ded_oe_n`, `fb_out[7]` is `ded_clk`, and `fb_out[1..6]` carry each cell's own pad level.
- R8: In registered mode (2'b01) a cell with `cfg_in_sel[i]`=0 is a registered cell. It loads its logic value in the `clk` cycle where `ded_clk` is 1 after being 0 in the previous cycle. It holds its value in every other cycle. `pad_out` (push-pull) shows the stored bit from the following cycle on.
- R9: In registered mode:
  - A registered cell is enabled only while `ded_oe_n` is 0, and its feedback is the inverse of its stored bit.
  - A cell with `cfg_in_sel[i]`=1 is combinational. Its enable is `pt_oe_in[i]` and its feedback is its pad level.
- R10: Reset clears every stored bit and the clock-pin edge history to 0.
- R11: A pad level is `pad_out[i]` while `pad_oe[i]` is 1, and `pad_in[i]` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Global mode word {sync, acc} |
| cfg_pol | input | 8 | Per-cell polarity bit |
| cfg_in_sel | input | 8 | Per-cell input/combinational select |
| cfg_od | input | 8 | Per-cell open-drain select |
| ded_clk | input | 1 | Dedicated pin: register clock or plain input |
| ded_oe_n | input | 1 | Dedicated pin: active-low output enable or plain input |
| sop_in | input | 8 | Sum-of-products result per cell |
| pt_oe_in | input | 8 | Product-term output enable per cell |
| pad_in | input | 8 | Level seen on each pad from outside |
| pad_out | output | 8 | Value driven on each pad |
| pad_oe | output | 8 | Drive enable of each pad |
| fb_out | output | 8 | Feedback signals to the logic array |

## Verification
Some rules are checked by assertions on every cycle:

- Open-drain pads never drive high.
- The reserved mode leaves every pad idle.
- Registered cells hold their value between clock-pin edges and fall silent while the global enable is high.
- The inner pair stays enabled in simple mode.
- Complex mode routes both dedicated pins into the end feedback slots.
- Reset clears the stored bits.

Other behaviour is shown only by the bench's scenarios, with a reference model compared on every clock:

- the exact neighbour mapping of simple-mode feedback;
- the moment a captured value appears after a clock-pin rise;
- the pad level seen through a released or tri-stated pad.

// File: rtl/olmc_pkg.sv
package olmc_pkg;

    typedef enum logic [1:0] {
        MODE_RSVD    = 2'b00,
        MODE_REG     = 2'b01,
        MODE_SIMPLE  = 2'b10,
        MODE_COMPLEX = 2'b11
    } olmc_mode_e;

    typedef struct packed {
        logic pol;
        logic in_sel;
        logic od;
    } cell_cfg_t;

    typedef struct packed {
        logic val;
        logic en;
    } drive_t;

    // Push-pull passes value and enable; open-drain pulls low or releases.
    function automatic drive_t shape_drive(logic d, logic e, logic od);
        drive_t r;
        if (od) begin
            r.val = 1'b0;
            r.en  = e & ~d;
        end else begin
            r.val = d;
            r.en  = e;
        end
        return r;
    endfunction

endpackage

// File: rtl/olmc_pin_edge.sv
module olmc_pin_edge (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= pin;
    end

    assign rise = pin & ~prev_q;

endmodule

// File: rtl/olmc_cell.sv
module olmc_cell
    import olmc_pkg::*;
#(
    parameter bit FORCE_OUT = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  olmc_mode_e mode,
    input  cell_cfg_t  cfg,
    input  logic       sop,
    input  logic       pt_oe,
    input  logic       oe_n,
    input  logic       cap,
    input  logic       pad_in,
    output logic       pad_out,
    output logic       pad_oe,
    output logic       level,
    output logic       reg_fb,
    output logic       is_reg
);
    logic   q;
    logic   v;
    logic   d;
    logic   e;
    drive_t drv;

    assign v      = sop ^ cfg.pol;
    assign is_reg = (mode == MODE_REG) && !cfg.in_sel;

    always_ff @(posedge clk) begin
        if (rst)             q <= 1'b0;
        else if (is_reg && cap) q <= v;
    end

    always_comb begin
        d = v;
        e = 1'b0;
        unique case (mode)
            MODE_SIMPLE:  e = FORCE_OUT | ~cfg.in_sel;
            MODE_COMPLEX: e = pt_oe;
            MODE_REG: begin
                if (!cfg.in_sel) begin
                    d = q;
                    e = ~oe_n;
                end else begin
                    e = pt_oe;
                end
            end
            default: begin
                d = 1'b0;
                e = 1'b0;
            end
        endcase
        drv = shape_drive(d, e, cfg.od);
    end

    assign pad_out = drv.val;
    assign pad_oe  = drv.en;
    assign level   = drv.en ? drv.val : pad_in;
    assign reg_fb  = ~q;

    // R3
    od_low_only_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.od && pad_oe) |-> !pad_out);

    // R8
    reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (is_reg && !cap) |=> $stable(q));

    // R9
    reg_oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (is_reg && oe_n) |-> !pad_oe);

    // R1
    rsvd_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RSVD) |-> (!pad_oe && !pad_out));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (q == 1'b0));

endmodule

// File: rtl/olmc_fb_router.sv
module olmc_fb_router
    import olmc_pkg::*;
#(
    parameter int N_CELLS = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  olmc_mode_e         mode,
    input  logic [N_CELLS-1:0] level,
    input  logic [N_CELLS-1:0] reg_fb,
    input  logic [N_CELLS-1:0] is_reg,
    input  logic               ded_clk,
    input  logic               ded_oe_n,
    output logic [N_CELLS-1:0] fb
);
    localparam int HALF = N_CELLS / 2;

    always_comb begin
        fb = '0;
        unique case (mode)
            MODE_REG: begin
                for (int i = 0; i < N_CELLS; i++)
                    fb[i] = is_reg[i] ? reg_fb[i] : level[i];
            end
            MODE_COMPLEX: begin
                fb            = level;
                fb[0]         = ded_oe_n;
                fb[N_CELLS-1] = ded_clk;
            end
            MODE_SIMPLE: begin
                for (int i = 1; i < HALF; i++)
                    fb[i] = level[i-1];
                for (int i = HALF; i < N_CELLS - 1; i++)
                    fb[i] = level[i+1];
                fb[0]         = ded_oe_n;
                fb[N_CELLS-1] = ded_clk;
            end
            default: fb = '0;
        endcase
    end

    // R7
    cplx_end_fb_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_COMPLEX) |-> (fb[0] == ded_oe_n && fb[N_CELLS-1] == ded_clk));

    // R1
    rsvd_fb_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RSVD) |-> (fb == '0));

endmodule

// File: rtl/pld_olmc_array.sv
module pld_olmc_array
    import olmc_pkg::*;
#(
    parameter int N_CELLS = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         cfg_mode,
    input  logic [N_CELLS-1:0] cfg_pol,
    input  logic [N_CELLS-1:0] cfg_in_sel,
    input  logic [N_CELLS-1:0] cfg_od,
    input  logic               ded_clk,
    input  logic               ded_oe_n,
    input  logic [N_CELLS-1:0] sop_in,
    input  logic [N_CELLS-1:0] pt_oe_in,
    input  logic [N_CELLS-1:0] pad_in,
    output logic [N_CELLS-1:0] pad_out,
    output logic [N_CELLS-1:0] pad_oe,
    output logic [N_CELLS-1:0] fb_out
);
    localparam int HALF = N_CELLS / 2;

    olmc_mode_e         mode;
    logic               cap;
    logic [N_CELLS-1:0] level;
    logic [N_CELLS-1:0] reg_fb;
    logic [N_CELLS-1:0] is_reg;

    assign mode = olmc_mode_e'(cfg_mode);

    olmc_pin_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .pin  (ded_clk),
        .rise (cap)
    );

    for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
        localparam bit INNER = (g == HALF - 1) || (g == HALF);
        olmc_cell #(.FORCE_OUT(INNER)) u_cell (
            .clk     (clk),
            .rst     (rst),
            .mode    (mode),
            .cfg     (cell_cfg_t'({cfg_pol[g], cfg_in_sel[g], cfg_od[g]})),
            .sop     (sop_in[g]),
            .pt_oe   (pt_oe_in[g]),
            .oe_n    (ded_oe_n),
            .cap     (cap),
            .pad_in  (pad_in[g]),
            .pad_out (pad_out[g]),
            .pad_oe  (pad_oe[g]),
            .level   (level[g]),
            .reg_fb  (reg_fb[g]),
            .is_reg  (is_reg[g])
        );
    end

    olmc_fb_router #(.N_CELLS(N_CELLS)) u_router (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .level    (level),
        .reg_fb   (reg_fb),
        .is_reg   (is_reg),
        .ded_clk  (ded_clk),
        .ded_oe_n (ded_oe_n),
        .fb       (fb_out)
    );

    // R4
    simple_inner_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SIMPLE && !cfg_od[HALF-1]) |-> pad_oe[HALF-1]);

    // R4
    simple_inner_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SIMPLE && !cfg_od[HALF]) |-> pad_oe[HALF]);

endmodule

// File: tb/tb_pld_olmc_array.sv
`timescale 1ns/1ps
module tb_pld_olmc_array;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cfg_mode = 2'b00;
    logic [7:0] cfg_pol = '0, cfg_in_sel = '0, cfg_od = '0;
    logic       ded_clk = 1'b0, ded_oe_n = 1'b0;
    logic [7:0] sop_in = '0, pt_oe_in = '0, pad_in = '0;
    logic [7:0] pad_out, pad_oe, fb_out;

    int checks = 0;
    int failures = 0;

    // model state
    bit [7:0] mq = '0;
    bit       mprev = 1'b0;

    always #2.5 clk = ~clk;

    pld_olmc_array dut (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_pol(cfg_pol),
        .cfg_in_sel(cfg_in_sel), .cfg_od(cfg_od), .ded_clk(ded_clk),
        .ded_oe_n(ded_oe_n), .sop_in(sop_in), .pt_oe_in(pt_oe_in),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .fb_out(fb_out)
    );

    task automatic expect_now(output bit [7:0] eo, output bit [7:0] ee, output bit [7:0] ef);
        bit [7:0] lvl;
        for (int i = 0; i < 8; i++) begin
            bit val, drv, en;
            val = sop_in[i] ^ cfg_pol[i];
            drv = val;
            en  = 1'b0;
            if (cfg_mode == 2'b10)
                en = (i == 3 || i == 4) ? 1'b1 : !cfg_in_sel[i];
            else if (cfg_mode == 2'b11)
                en = pt_oe_in[i];
            else if (cfg_mode == 2'b01) begin
                if (cfg_in_sel[i]) en = pt_oe_in[i];
                else begin drv = mq[i]; en = !ded_oe_n; end
            end else begin
                drv = 1'b0;
            end
            if (cfg_od[i]) begin
                eo[i] = 1'b0;
                ee[i] = en && !drv;
            end else begin
                eo[i] = drv;
                ee[i] = en;
            end
            lvl[i] = ee[i] ? eo[i] : pad_in[i];
        end
        ef = '0;
        case (cfg_mode)
            2'b01: for (int i = 0; i < 8; i++) ef[i] = cfg_in_sel[i] ? lvl[i] : !mq[i];
            2'b11: begin ef = lvl; ef[0] = ded_oe_n; ef[7] = ded_clk; end
            2'b10: begin
                ef[0] = ded_oe_n; ef[7] = ded_clk;
                ef[1] = lvl[0]; ef[2] = lvl[1]; ef[3] = lvl[2];
                ef[4] = lvl[5]; ef[5] = lvl[6]; ef[6] = lvl[7];
            end
            default: ef = '0;
        endcase
    endtask

    task automatic cmp(input string tag, input string what, input logic [7:0] act, input bit [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b mode=%b", tag, what, act, exp, cfg_mode);
        end
    endtask

    // Called just after a negedge with inputs set; compares, then advances one clock.
    task automatic step(input string tag);
        bit [7:0] eo, ee, ef;
        #1;
        expect_now(eo, ee, ef);
        cmp(tag, "pad_out", pad_out, eo);
        cmp(tag, "pad_oe", pad_oe, ee);
        cmp(tag, "fb_out", fb_out, ef);
        @(posedge clk);
        if (rst) begin
            mq = '0; mprev = 1'b0;
        end else begin
            if (ded_clk && !mprev && cfg_mode == 2'b01)
                for (int i = 0; i < 8; i++)
                    if (!cfg_in_sel[i]) mq[i] = sop_in[i] ^ cfg_pol[i];
            mprev = ded_clk;
        end
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R10: reset state, reserved mode while in reset
        step("R10"); step("R10");
        rst = 1'b0;
        // R10: registered cells show cleared bits after reset
        cfg_mode = 2'b01; sop_in = 8'hFF; ded_oe_n = 1'b0;
        step("R10");
        // R1: reserved mode ignores everything
        cfg_mode = 2'b00; pt_oe_in = 8'hFF; pad_in = 8'hFF; cfg_pol = 8'h5A;
        step("R1"); ded_clk = 1'b1; step("R1"); ded_clk = 1'b0; step("R1");
        // R2: polarity in simple mode
        cfg_mode = 2'b10; cfg_in_sel = '0; cfg_od = '0;
        cfg_pol = 8'h00; sop_in = 8'hC3; step("R2");
        cfg_pol = 8'hFF; step("R2");
        cfg_pol = 8'h0F; sop_in = 8'h55; step("R2");
        // R3: open drain
        cfg_od = 8'hFF; cfg_pol = 8'h00; sop_in = 8'hA5; step("R3");
        cfg_od = 8'h0F; sop_in = 8'h3C; pad_in = 8'h81; step("R3");
        cfg_od = '0;
        // R4: inputs tri-stated, inner pair forced out
        cfg_in_sel = 8'hFF; pad_in = 8'hE7; sop_in = 8'h18; step("R4");
        cfg_in_sel = 8'h5A; step("R4");
        // R5 / R11: simple feedback from neighbours
        cfg_in_sel = 8'hE7; pad_in = 8'b1010_0101; ded_oe_n = 1'b1; ded_clk = 1'b0; step("R5");
        pad_in = 8'b0101_1010; ded_oe_n = 1'b0; ded_clk = 1'b1; step("R11");
        cfg_in_sel = 8'h00; sop_in = 8'h96; step("R5");
        ded_clk = 1'b0;
        // R6 / R7: complex mode
        cfg_mode = 2'b11; cfg_in_sel = '0; pt_oe_in = 8'h0F; sop_in = 8'hF0; pad_in = 8'hAA; step("R6");
        pt_oe_in = 8'hF0; ded_oe_n = 1'b1; ded_clk = 1'b1; step("R7");
        pt_oe_in = 8'h3C; cfg_od = 8'hC3; step("R7");
        cfg_od = '0; ded_clk = 1'b0; ded_oe_n = 1'b0;
        // R8: capture on clock-pin rise only
        cfg_mode = 2'b01; cfg_in_sel = 8'h00; cfg_pol = 8'h00; sop_in = 8'hA5; step("R8");
        ded_clk = 1'b1; step("R8");
        sop_in = 8'h3C; step("R8"); step("R8");
        ded_clk = 1'b0; step("R8");
        ded_clk = 1'b1; cfg_pol = 8'hFF; step("R8");
        ded_clk = 1'b0; step("R8");
        // R9: global enable gating, inverted feedback, combinational cells
        ded_oe_n = 1'b1; step("R9");
        cfg_in_sel = 8'h33; pt_oe_in = 8'h21; pad_in = 8'h5A; step("R9");
        ded_oe_n = 1'b0; cfg_od = 8'h11; step("R9");
        cfg_od = '0;
        // mixed patterns across all modes
        for (int n = 0; n < 3000; n++) begin
            cfg_mode   = 2'($urandom);
            cfg_pol    = 8'($urandom); cfg_in_sel = 8'($urandom); cfg_od = 8'($urandom);
            sop_in     = 8'($urandom); pt_oe_in = 8'($urandom); pad_in = 8'($urandom);
            ded_clk    = 1'($urandom); ded_oe_n = 1'($urandom);
            if (n % 500 == 7) rst = 1'b1; else rst = 1'b0;
            case (cfg_mode)
                2'b00:   step("R1");
                2'b01:   step("R8");
                2'b10:   step("R5");
                default: step("R7");
            endcase
        end
        rst = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule